// File: doc/BRIEF.md
# Hotline Address Translation Unit

This unit turns the virtual address of a nonscalar load or store into a word address inside a tagless data SRAM. Each request carries a compiler-chosen index into a small file of hotline registers. Each hotline register holds one mapping from a virtual line to an SRAM line. When the selected register matches the request's virtual line, the SRAM address comes out in the same cycle. If it does not match, a small fully associative translation buffer is searched in the next cycle. A buffer hit completes the access and refreshes the selected hotline register.

When both levels miss, the unit holds the request and raises a trap for a software handler. The handler finds or fetches the line and writes the resolved mapping back through an update port. That write completes the held access. It also installs the mapping in the buffer, replacing entries in round-robin order, and in the held hotline register. The line size is a runtime setting of 64, 256 or 1024 bytes, which moves the boundary between line address and line offset. Three counters let software measure prediction rates.

Virtual and SRAM line addresses on the update port are given in 64-byte units, which is the smallest line. For larger lines the handler supplies a line-aligned SRAM base.

Top module: `hotline_xlate`

## Requirements
- R1: After reset, every hotline register and buffer entry is invalid, all three counters read 0, and `busy`, `trap` and `resp_valid` are low, so the first access to any index misses both levels.
- R2: An accepted request (`req_valid` high while `busy` is low) whose virtual line equals the line held in valid hotline register `req_idx` gives `resp_valid` in that same cycle. It has `resp_src` = 0 (hotline) and `resp_addr` = the stored SRAM line with its low line-offset bits replaced by the request's address bits.
- R3: `lsz_mode` encodes the line size: 0 = 64 B (6 offset bits), 1 = 256 B (8 bits), 2 and 3 = 1024 B (10 bits). Both the line compare at each level and the offset join use this boundary.
- R4: A request that misses its hotline register raises `busy` on the next cycle and searches the buffer in that cycle. On a buffer hit, `resp_valid` rises in that cycle with `resp_src` = 1 (buffer), and `busy` falls after it.
- R5: A buffer hit overwrites hotline register `req_idx` with the found mapping, so a later request with the same index and line hits in the hotline.
- R6: A buffer miss asserts `trap` from the cycle after the buffer search. `trap_va` shows the held virtual address. `busy` and `trap` stay high, with no response, until an update arrives.
- R7: While `trap` is high, `upd_valid` completes the held access in that cycle. The response has `resp_src` = 2 (handler) and an address built from `upd_sline` and the held offset. The update installs the mapping into the buffer and the held hotline register, and `trap` and `busy` drop on the next cycle.
- R8: `upd_valid` while no trap is pending has no effect: no response, and nothing is installed.
- R9: Buffer installs use a round-robin pointer that advances on each install, so the 17th install replaces the oldest entry and leaves the other 15 in place.
- R10: `cnt_hot`, `cnt_buf` and `cnt_trap` each increase by one on every hotline hit, buffer hit and trap respectively.
- R11: A request presented while `busy` is high is ignored.
- R12: Hotline registers are selected only by `req_idx`: a mapping held under one index gives no hotline hit for a request using another index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsz_mode | input | 2 | Line size select (R3) |
| req_valid | input | 1 | Request strobe |
| req_va | input | 32 | Virtual byte address of the request |
| req_idx | input | 3 | Compiler-chosen hotline register index |
| upd_valid | input | 1 | Handler update strobe |
| upd_vline | input | 26 | Resolved virtual line address, 64-byte units |
| upd_sline | input | 10 | Resolved SRAM line address, 64-byte units |
| busy | output | 1 | Request held; new requests ignored |
| resp_valid | output | 1 | Translation complete this cycle |
| resp_src | output | 2 | 0 hotline, 1 buffer, 2 handler |
| resp_addr | output | 16 | SRAM byte address |
| trap | output | 1 | Both levels missed; handler needed |
| trap_va | output | 32 | Virtual address of the held request |
| cnt_hot | output | 16 | Hotline hit counter |
| cnt_buf | output | 16 | Buffer hit counter |
| cnt_trap | output | 16 | Trap counter |

## Verification
The translation path is exercised with three patterns that separate the levels. The first is a repeat of the same line and index, which must hit the hotline in the request cycle. The second is the same line under a fresh index, which must miss the hotline but hit the buffer a cycle later. The third is a new line, which must trap until the handler's write. The line-size modes are told apart by addresses that match a stored line under a coarse size but not under a fine one, and by offsets that differ only above bit 8. Idle updates and requests made while trapped are checked by following each with an access that would expose any change. The round-robin order is shown by filling the buffer past its depth: afterwards the oldest line traps while the second-oldest still hits.

// File: rtl/hx_pkg.sv
package hx_pkg;

  // smallest line is 64 bytes; larger lines mask more low line-address bits
  localparam int unsigned MIN_OFF = 6;

  typedef enum logic [1:0] {
    SRC_HOT = 2'd0,
    SRC_BUF = 2'd1,
    SRC_SW  = 2'd2
  } hx_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_TRAP = 2'd2
  } hx_state_e;

  // extra offset bits above MIN_OFF for each line size mode
  function automatic int unsigned extra_off(input logic [1:0] mode);
    case (mode)
      2'd0:    extra_off = 0;
      2'd1:    extra_off = 2;
      default: extra_off = 4;
    endcase
  endfunction

endpackage

// File: rtl/hx_hotline_file.sv
module hx_hotline_file #(
  parameter int unsigned HL_N = 8,
  parameter int unsigned VL_W = 26,
  parameter int unsigned SL_W = 10,
  localparam int unsigned HL_IW = $clog2(HL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HL_IW-1:0]  rd_idx,
  input  logic [VL_W-1:0]   rd_vline,   // already masked to the line size
  input  logic [VL_W-1:0]   vl_mask,
  input  logic              wr_en,
  input  logic [HL_IW-1:0]  wr_idx,
  input  logic [VL_W-1:0]   wr_vline,
  input  logic [SL_W-1:0]   wr_sline,
  output logic              hit,
  output logic [SL_W-1:0]   rd_sline
);

  logic [HL_N-1:0]  valid_q;
  logic [HL_N-1:0]  valid_d;
  logic [HL_N-1:0]  wr_sel;
  logic [VL_W-1:0]  vline_q [HL_N];
  logic [SL_W-1:0]  sline_q [HL_N];

  always_comb begin
    wr_sel = '0;
    if (wr_en) wr_sel[wr_idx] = 1'b1;
    valid_d = valid_q | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < HL_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        vline_q[g] <= wr_vline;
        sline_q[g] <= wr_sline;
      end
    end
  end

  always_comb begin
    rd_sline = sline_q[rd_idx];
    hit      = valid_q[rd_idx] && ((vline_q[rd_idx] & vl_mask) == rd_vline);
  end

endmodule

// File: rtl/hx_xlate_buffer.sv
module hx_xlate_buffer #(
  parameter int unsigned BUF_N = 16,
  parameter int unsigned VL_W  = 26,
  parameter int unsigned SL_W  = 10,
  localparam int unsigned BUF_IW = $clog2(BUF_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VL_W-1:0]   look_vline,  // already masked to the line size
  input  logic [VL_W-1:0]   vl_mask,
  input  logic              ins_en,
  input  logic [VL_W-1:0]   ins_vline,
  input  logic [SL_W-1:0]   ins_sline,
  output logic              hit,
  output logic [SL_W-1:0]   hit_sline
);

  logic [BUF_N-1:0]  valid_q;
  logic [BUF_N-1:0]  valid_d;
  logic [BUF_N-1:0]  ins_sel;
  logic [BUF_N-1:0]  match;
  logic [BUF_IW-1:0] rr_q;
  logic [BUF_IW-1:0] rr_d;
  logic [BUF_IW-1:0] hit_idx;
  logic [VL_W-1:0]   vline_q [BUF_N];
  logic [SL_W-1:0]   sline_q [BUF_N];

  // round-robin victim pointer, advances once per install
  always_comb begin
    ins_sel = '0;
    if (ins_en) ins_sel[rr_q] = 1'b1;
    valid_d = valid_q | ins_sel;
    rr_d    = rr_q;
    if (ins_en) begin
      if (rr_q == BUF_IW'(BUF_N - 1)) rr_d = '0;
      else                            rr_d = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  for (genvar g = 0; g < BUF_N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (ins_sel[g]) begin
        vline_q[g] <= ins_vline;
        sline_q[g] <= ins_sline;
      end
    end
    assign match[g] = valid_q[g] && ((vline_q[g] & vl_mask) == look_vline);
  end

  // lowest matching entry wins
  always_comb begin
    hit_idx = '0;
    for (int i = BUF_N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = BUF_IW'(i);
    end
    hit       = |match;
    hit_sline = sline_q[hit_idx];
  end

endmodule

// File: rtl/hx_ctrl.sv
module hx_ctrl
  import hx_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              hot_hit,
  input  logic              buf_hit,
  input  logic              upd_valid,
  output hx_state_e         state,
  output logic              cap_en,
  output logic              hot_wr_en,
  output logic              buf_ins_en,
  output logic              resp_valid,
  output hx_src_e           resp_src,
  output logic [CNT_W-1:0]  cnt_hot,
  output logic [CNT_W-1:0]  cnt_buf,
  output logic [CNT_W-1:0]  cnt_trap
);

  hx_state_e        st_q, st_d;
  logic             inc_hot, inc_buf, inc_trap;
  logic [CNT_W-1:0] hot_q, buf_q, trap_q;

  always_comb begin
    st_d       = st_q;
    cap_en     = 1'b0;
    hot_wr_en  = 1'b0;
    buf_ins_en = 1'b0;
    resp_valid = 1'b0;
    resp_src   = SRC_HOT;
    inc_hot    = 1'b0;
    inc_buf    = 1'b0;
    inc_trap   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (hot_hit) begin
            resp_valid = 1'b1;
            inc_hot    = 1'b1;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_LOOK;
          end
        end
      end
      ST_LOOK: begin
        if (buf_hit) begin
          resp_valid = 1'b1;
          resp_src   = SRC_BUF;
          hot_wr_en  = 1'b1;
          inc_buf    = 1'b1;
          st_d       = ST_IDLE;
        end else begin
          inc_trap = 1'b1;
          st_d     = ST_TRAP;
        end
      end
      ST_TRAP: begin
        if (upd_valid) begin
          resp_valid = 1'b1;
          resp_src   = SRC_SW;
          hot_wr_en  = 1'b1;
          buf_ins_en = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hot_q  <= '0;
      buf_q  <= '0;
      trap_q <= '0;
    end else begin
      st_q <= st_d;
      if (inc_hot)  hot_q  <= hot_q + 1'b1;
      if (inc_buf)  buf_q  <= buf_q + 1'b1;
      if (inc_trap) trap_q <= trap_q + 1'b1;
    end
  end

  assign state    = st_q;
  assign cnt_hot  = hot_q;
  assign cnt_buf  = buf_q;
  assign cnt_trap = trap_q;

endmodule

// File: rtl/hotline_xlate.sv
module hotline_xlate
  import hx_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned SA_W  = 16,
  parameter int unsigned HL_N  = 8,
  parameter int unsigned BUF_N = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned HL_IW = $clog2(HL_N),
  localparam int unsigned VL_W  = VA_W - MIN_OFF,
  localparam int unsigned SL_W  = SA_W - MIN_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lsz_mode,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [HL_IW-1:0]  req_idx,
  input  logic              upd_valid,
  input  logic [VL_W-1:0]   upd_vline,
  input  logic [SL_W-1:0]   upd_sline,
  output logic              busy,
  output logic              resp_valid,
  output logic [1:0]        resp_src,
  output logic [SA_W-1:0]   resp_addr,
  output logic              trap,
  output logic [VA_W-1:0]   trap_va,
  output logic [CNT_W-1:0]  cnt_hot,
  output logic [CNT_W-1:0]  cnt_buf,
  output logic [CNT_W-1:0]  cnt_trap
);

  hx_state_e        state;
  hx_src_e          src;
  logic             cap_en, hot_wr_en, buf_ins_en;
  logic             hot_hit, buf_hit;
  logic [SL_W-1:0]  hot_sline, buf_sline, sel_sline;
  logic [VL_W-1:0]  vl_mask;
  logic [SA_W-1:0]  off_mask;
  logic [VA_W-1:0]  va_q;
  logic [HL_IW-1:0] idx_q;
  logic [VA_W-1:0]  sel_va;
  logic [VL_W-1:0]  wr_vline;
  logic [SL_W-1:0]  wr_sline;

  // line size boundary
  always_comb begin
    vl_mask  = '1 << extra_off(lsz_mode);
    off_mask = ~('1 << (MIN_OFF + extra_off(lsz_mode)));
  end

  // held request (captured on a hotline miss)
  always_ff @(posedge clk) begin
    if (cap_en) begin
      va_q  <= req_va;
      idx_q <= req_idx;
    end
  end

  // hotline write source: buffer result while searching, handler otherwise
  always_comb begin
    if (state == ST_LOOK) begin
      wr_vline = va_q[VA_W-1:MIN_OFF] & vl_mask;
      wr_sline = buf_sline;
    end else begin
      wr_vline = upd_vline & vl_mask;
      wr_sline = upd_sline;
    end
  end

  hx_hotline_file #(
    .HL_N (HL_N),
    .VL_W (VL_W),
    .SL_W (SL_W)
  ) u_hot (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_vline (req_va[VA_W-1:MIN_OFF] & vl_mask),
    .vl_mask  (vl_mask),
    .wr_en    (hot_wr_en),
    .wr_idx   (idx_q),
    .wr_vline (wr_vline),
    .wr_sline (wr_sline),
    .hit      (hot_hit),
    .rd_sline (hot_sline)
  );

  hx_xlate_buffer #(
    .BUF_N (BUF_N),
    .VL_W  (VL_W),
    .SL_W  (SL_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vline (va_q[VA_W-1:MIN_OFF] & vl_mask),
    .vl_mask    (vl_mask),
    .ins_en     (buf_ins_en),
    .ins_vline  (upd_vline & vl_mask),
    .ins_sline  (upd_sline),
    .hit        (buf_hit),
    .hit_sline  (buf_sline)
  );

  hx_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .hot_hit    (hot_hit),
    .buf_hit    (buf_hit),
    .upd_valid  (upd_valid),
    .state      (state),
    .cap_en     (cap_en),
    .hot_wr_en  (hot_wr_en),
    .buf_ins_en (buf_ins_en),
    .resp_valid (resp_valid),
    .resp_src   (src),
    .cnt_hot    (cnt_hot),
    .cnt_buf    (cnt_buf),
    .cnt_trap   (cnt_trap)
  );

  // SRAM address: line base from the resolving level, offset from the request
  always_comb begin
    case (state)
      ST_LOOK: sel_sline = buf_sline;
      ST_TRAP: sel_sline = upd_sline;
      default: sel_sline = hot_sline;
    endcase
    sel_va    = (state == ST_IDLE) ? req_va : va_q;
    resp_addr = ({sel_sline, {MIN_OFF{1'b0}}} & ~off_mask) | (sel_va[SA_W-1:0] & off_mask);
  end

  assign resp_src = src;
  assign busy     = (state != ST_IDLE);
  assign trap     = (state == ST_TRAP);
  assign trap_va  = va_q;

endmodule

// File: rtl/hx_checker.sv
module hx_checker #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             upd_valid,
  input logic             busy,
  input logic             resp_valid,
  input logic [1:0]       resp_src,
  input logic             trap,
  input logic [VA_W-1:0]  trap_va,
  input logic [CNT_W-1:0] cnt_hot,
  input logic [CNT_W-1:0] cnt_trap
);

  // R2: an idle-cycle response only comes from a hotline hit on a live request
  p_idle_resp_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !busy) |-> (req_valid && resp_src == 2'd0));

  // R2: source code is never the unused value
  p_src_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_src != 2'd3));

  // R4: a hotline miss on an accepted request makes the unit busy next cycle
  p_miss_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !resp_valid) |=> (busy && !trap));

  // R4: the buffer search lasts exactly one cycle
  p_look_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trap) |=> !(busy && !trap));

  // R6: trap implies busy and is held with a stable address until updated
  p_trap_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> busy);
  p_trap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !upd_valid) |=> (trap && $stable(trap_va)));

  // R7: update during trap answers at once and releases next cycle
  p_upd_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && upd_valid) |-> (resp_valid && resp_src == 2'd2));
  p_upd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && upd_valid) |=> !busy);

  // R10: counters step on their events
  p_cnt_hot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_src == 2'd0) |=> ((cnt_hot - $past(cnt_hot)) == CNT_W'(1)));
  p_cnt_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap) |-> ((cnt_trap - $past(cnt_trap)) == CNT_W'(1)));

endmodule

bind hotline_xlate hx_checker #(
  .VA_W  (VA_W),
  .CNT_W (CNT_W)
) u_hx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .upd_valid  (upd_valid),
  .busy       (busy),
  .resp_valid (resp_valid),
  .resp_src   (resp_src),
  .trap       (trap),
  .trap_va    (trap_va),
  .cnt_hot    (cnt_hot),
  .cnt_trap   (cnt_trap)
);

// File: tb/tb_hotline_xlate.sv
`timescale 1ns/1ps
module tb_hotline_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  lsz_mode;
  logic        req_valid;
  logic [31:0] req_va;
  logic [2:0]  req_idx;
  logic        upd_valid;
  logic [25:0] upd_vline;
  logic [9:0]  upd_sline;
  logic        busy, resp_valid, trap;
  logic [1:0]  resp_src;
  logic [15:0] resp_addr;
  logic [31:0] trap_va;
  logic [15:0] cnt_hot, cnt_buf, cnt_trap;

  hotline_xlate dut (
    .clk(clk), .rst_n(rst_n), .lsz_mode(lsz_mode),
    .req_valid(req_valid), .req_va(req_va), .req_idx(req_idx),
    .upd_valid(upd_valid), .upd_vline(upd_vline), .upd_sline(upd_sline),
    .busy(busy), .resp_valid(resp_valid), .resp_src(resp_src),
    .resp_addr(resp_addr), .trap(trap), .trap_va(trap_va),
    .cnt_hot(cnt_hot), .cnt_buf(cnt_buf), .cnt_trap(cnt_trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] addr;
    logic [1:0]  src;
    string       rq;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int exp_hot = 0, exp_buf = 0, exp_trap = 0;
  bit done = 0;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [15:0] base,
                                     input logic [31:0] va,
                                     input logic [1:0] m);
    int o;
    logic [15:0] msk;
    o   = (m == 2'd0) ? 6 : (m == 2'd1) ? 8 : 10;
    msk = 16'((1 << o) - 1);
    return (base & ~msk) | (va[15:0] & msk);
  endfunction

  task automatic expect_resp(input logic [15:0] addr, input logic [1:0] src,
                             input string rq);
    exp_t e;
    e.addr = addr; e.src = src; e.rq = rq;
    q.push_back(e);
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q.size() == 0) begin
        chk("R11/R8", "unexpected response", {14'd0, resp_src, resp_addr}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.rq, "resp_src", {30'd0, resp_src}, {30'd0, e.src});
        chk(e.rq, "resp_addr", {16'd0, resp_addr}, {16'd0, e.addr});
      end
    end
  end

  task automatic do_req(input logic [31:0] va, input logic [2:0] idx);
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_va = va; req_idx = idx;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic req_hot(input logic [31:0] va, input logic [2:0] idx,
                         input logic [15:0] base, input string rq);
    expect_resp(mk(base, va, lsz_mode), 2'd0, rq);
    exp_hot++;
    do_req(va, idx);
  endtask

  task automatic req_buf(input logic [31:0] va, input logic [2:0] idx,
                         input logic [15:0] base, input string rq);
    expect_resp(mk(base, va, lsz_mode), 2'd1, rq);
    exp_buf++;
    do_req(va, idx);
    @(negedge clk);
    chk(rq, "busy during buffer search", {31'd0, busy}, 32'd1);
  endtask

  task automatic req_trap(input logic [31:0] va, input logic [2:0] idx, input string rq);
    exp_trap++;
    do_req(va, idx);
    @(negedge clk);
    chk(rq, "busy/trap in search cycle", {30'd0, busy, trap}, 32'd2);
    @(negedge clk);
    chk(rq, "trap raised", {31'd0, trap}, 32'd1);
    chk(rq, "trap_va", trap_va, va);
  endtask

  task automatic resolve(input logic [31:0] va, input logic [15:0] base, input string rq);
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_vline = va[31:6]; upd_sline = base[15:6];
    expect_resp(mk(base, va, lsz_mode), 2'd2, rq);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    @(negedge clk);
    chk(rq, "released after update", {30'd0, busy, trap}, 32'd0);
  endtask

  task automatic chk_counters(input string rq);
    @(negedge clk);
    chk(rq, "cnt_hot",  {16'd0, cnt_hot},  32'(exp_hot));
    chk(rq, "cnt_buf",  {16'd0, cnt_buf},  32'(exp_buf));
    chk(rq, "cnt_trap", {16'd0, cnt_trap}, 32'(exp_trap));
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lsz_mode = 2'd1;
    req_valid = 1'b0; req_va = '0; req_idx = '0;
    upd_valid = 1'b0; upd_vline = '0; upd_sline = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1", "busy/trap/resp", {29'd0, busy, trap, resp_valid}, 32'd0);
    chk_counters("R1");

    // R1/R6/R7: first access traps, handler resolves
    req_trap(32'h0001_2345, 3'd3, "R6");
    resolve(32'h0001_2345, 16'h0400, "R7");
    // R2: same line, same index hits the hotline in the request cycle
    req_hot(32'h0001_2378, 3'd3, 16'h0400, "R2");
    // R4/R5: fresh index, line is in the buffer
    req_buf(32'h0001_2300, 3'd5, 16'h0400, "R4");
    req_hot(32'h0001_23C0, 3'd5, 16'h0400, "R5");
    req_hot(32'h0001_2301, 3'd3, 16'h0400, "R12");
    // R12: other line on index 3 misses everywhere
    req_trap(32'h0001_2400, 3'd3, "R12");
    resolve(32'h0001_2400, 16'h0800, "R12");
    req_buf(32'h0001_2345, 3'd3, 16'h0400, "R5");
    chk_counters("R10");

    // R3: line-size modes
    lsz_mode = 2'd2;
    req_hot(32'h0001_20AB, 3'd3, 16'h0400, "R3");
    lsz_mode = 2'd3;
    req_hot(32'h0001_23FF, 3'd3, 16'h0400, "R3");
    lsz_mode = 2'd0;
    req_hot(32'h0001_2300, 3'd3, 16'h0400, "R3");
    req_trap(32'h0001_2340, 3'd3, "R3");
    resolve(32'h0001_2340, 16'h0C40, "R3");
    lsz_mode = 2'd1;

    // R8: idle update has no effect
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_vline = 26'(32'h5000_0000 >> 6); upd_sline = 10'(16'h1000 >> 6);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    req_trap(32'h5000_0000, 3'd0, "R8");
    // R11: request while trapped is ignored
    @(posedge clk); #1;
    req_valid = 1'b1; req_va = 32'h0001_2378; req_idx = 3'd3;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11", "still trapped", {31'd0, trap}, 32'd1);
    resolve(32'h5000_0000, 16'h1000, "R8");
    chk_counters("R10");

    // R9: fill buffer (4 installs so far), then 17th install evicts the oldest
    lsz_mode = 2'd0;
    req_buf(32'h0001_2300, 3'd4, 16'h0400, "R9");
    lsz_mode = 2'd1;
    for (int k = 0; k < 12; k++) begin
      req_trap(32'h6000_0000 + 32'(k) * 32'h100, 3'd7, "R9");
      resolve(32'h6000_0000 + 32'(k) * 32'h100, 16'h2000 + 16'(k) * 16'h100, "R9");
    end
    req_trap(32'h7000_0000, 3'd7, "R9");
    resolve(32'h7000_0000, 16'h3000, "R9");
    req_buf(32'h0001_2400, 3'd2, 16'h0800, "R9");
    lsz_mode = 2'd0;
    req_trap(32'h0001_2300, 3'd2, "R9");
    resolve(32'h0001_2300, 16'h3400, "R9");
    lsz_mode = 2'd1;
    chk_counters("R10");

    repeat (3) @(negedge clk);
    chk("R2", "all expected responses seen", 32'(q.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule